// File: doc/BRIEF.md
# Resynchronizing antenna-carrier transmit buffer

This block moves 32-bit antenna-carrier samples from a slow application clock into a faster line-side clock. It has one instance per channel. Flow control is not used. The application realigns the buffer by pulsing a resync strobe, and the ready output stays high permanently. A resync clears the write pointer in the application domain. A synchronized copy of the strobe clears the read pointer on the line side, so both pointers restart at entry zero. Any samples that were still in flight are dropped.

The buffer has 16 entries by default. Its pointers cross between the clock domains in Gray code. After a resync, the line side withholds output until the buffer holds at least half its depth. Until then, read strobes are ignored, the output word is zero and the output valid flag is low. Two sticky error flags are provided, and both are cleared by the next resync:

- an overflow flag in the application domain;
- an underflow flag in the line domain.

Top module: `axc_resync_txbuf`

## Requirements
- R1: `app_ready` is 1 in every cycle after reset, whatever the other inputs do.
- R2: When resync and valid are high in the same application cycle, that cycle's sample is the first one emitted after the realignment.
- R3: When resync is high with valid low, the data bus is ignored in that cycle, and the sample written in the next valid cycle is the first one emitted.
- R4: A sample is stored only in application cycles where valid is 1; cycles with valid 0 add nothing to the stream.
- R5: A resync discards every sample written before it that has not yet been emitted.
- R6: Until the buffer holds at least DEPTH/2 samples after a resync (8 by default), read strobes are ignored: `line_dvalid` stays 0, `line_data` stays 0 and no sample is consumed.
- R7: Once primed, samples leave in write order. Each read strobe on a non-empty buffer raises `line_dvalid`, with the sample on `line_data`, in the line cycle that follows the strobe.
- R8: A write that arrives while the buffer holds DEPTH samples is dropped and sets `app_ovf` to 1.
- R9: A read strobe while primed and empty sets `line_unf` to 1 and returns `line_dvalid` 0.
- R10: Both error flags stay at 1 until the next resync, which returns them to 0.
- R11: After reset, `line_dvalid`, `line_data`, `app_ovf` and `line_unf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| app_clk | input | 1 | Application-side sample clock |
| app_rst_n | input | 1 | Active-low asynchronous reset, application domain |
| app_resync | input | 1 | Realignment strobe, one application cycle |
| app_valid | input | 1 | Sample on `app_data` is to be stored |
| app_data | input | DATA_W | Antenna-carrier sample |
| app_ready | output | 1 | Constant 1 in this mode |
| app_ovf | output | 1 | Sticky overflow flag |
| line_clk | input | 1 | Line-side frame clock |
| line_rst_n | input | 1 | Active-low asynchronous reset, line domain |
| line_rd | input | 1 | Read strobe from the framer |
| line_data | output | DATA_W | Emitted sample, zero when not valid |
| line_dvalid | output | 1 | `line_data` carries a sample |
| line_unf | output | 1 | Sticky underflow flag |

## Verification
A write pointer that fails to clear on resync shows up at the first read after priming: stale or skipped samples appear on `line_data`. This happens a few line cycles after the fill reaches half depth. A read pointer that fails to clear, or a priming threshold that is off by one, changes either the first word or the cycle where `line_dvalid` first rises. The bench sweeps stream lengths from half to full depth, with idle gaps, so every fill level from 8 to 16 is read back in full. A wrong fill count shows up as early as the one extra read after each stream, which must report underflow and no data. The same error also shows as a dropped sample at full depth.

// File: rtl/axc_txbuf_pkg.sv
package axc_txbuf_pkg;

  localparam int SAMPLE_W  = 32;
  localparam int BUF_DEPTH = 16;

  // pointer width: address bits plus one wrap bit
  function automatic int ptr_bits(input int depth);
    return $clog2(depth) + 1;
  endfunction

  // fill level at which the line side starts emitting
  function automatic int prime_level(input int depth);
    return depth / 2;
  endfunction

endpackage

// File: rtl/axc_bit_sync.sv
module axc_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/axc_ptr_xing.sv
module axc_ptr_xing #(
  parameter int PW = 5
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [PW-1:0] dst_bin
);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  logic [PW-1:0] gray_src;
  logic [PW-1:0] gray_dst;

  // register the Gray code so only one bit moves per source edge
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_src <= '0;
    else            gray_src <= to_gray(src_bin);
  end

  axc_bit_sync #(.W(PW)) u_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (gray_src),
    .q     (gray_dst)
  );

  assign dst_bin = from_gray(gray_dst);

endmodule

// File: rtl/axc_txbuf_wr.sv
module axc_txbuf_wr #(
  parameter int DEPTH = 16,
  parameter int HOLD  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int HW   = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resync,
  input  logic          valid,
  input  logic [PW-1:0] rptr_sync,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] fill,
  output logic          full,
  output logic          rs_level,
  output logic          ovf
);

  logic [PW-1:0] wptr_q;
  logic [HW-1:0] hold_q;
  logic          rs_q1;
  logic          rs_q2;
  logic          ovf_q;
  logic [PW-1:0] rbase;

  // right after a resync the synchronized read pointer is stale;
  // the line side is known to restart from zero, so compare against that
  assign rbase   = (hold_q != '0) ? '0 : rptr_sync;
  assign fill    = wptr_q - rbase;
  assign full    = (fill == PW'(DEPTH));
  assign wr_en   = valid && (resync || !full);
  assign wr_addr = resync ? '0 : wptr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      hold_q <= '0;
      rs_q1  <= 1'b0;
      rs_q2  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      rs_q1 <= resync;
      rs_q2 <= rs_q1;
      if (resync) begin
        wptr_q <= valid ? PW'(1) : '0;
        hold_q <= HW'(HOLD);
        ovf_q  <= 1'b0;
      end else begin
        if (wr_en)          wptr_q <= wptr_q + PW'(1);
        if (hold_q != '0)   hold_q <= hold_q - HW'(1);
        if (valid && full)  ovf_q  <= 1'b1;
      end
    end
  end

  // stretched so the restarted write pointer settles before release
  assign rs_level = rs_q1 | rs_q2;
  assign wptr     = wptr_q;
  assign ovf      = ovf_q;

endmodule

// File: rtl/axc_txbuf_rd.sv
module axc_txbuf_rd #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int HALF = axc_txbuf_pkg::prime_level(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rs_level,
  input  logic [PW-1:0] wptr_sync,
  input  logic          rd_req,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] fill,
  output logic          primed,
  output logic          rd_fire,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          unf
);

  logic          rs_sync;
  logic          rs_prev;
  logic          rs_rise;
  logic [PW-1:0] rptr_q;
  logic          primed_q;
  logic          empty;
  logic [DW-1:0] data_q;
  logic          valid_q;
  logic          unf_q;

  axc_bit_sync #(.W(1)) u_rs_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rs_level),
    .q     (rs_sync)
  );

  assign rs_rise = rs_sync && !rs_prev;
  assign fill    = wptr_sync - rptr_q;
  assign empty   = (fill == '0);
  assign rd_fire = rd_req && primed_q && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_prev  <= 1'b0;
      rptr_q   <= '0;
      primed_q <= 1'b0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      rs_prev <= rs_sync;
      if (rs_sync) begin
        rptr_q   <= '0;
        primed_q <= 1'b0;
      end else begin
        if (rd_fire) rptr_q <= rptr_q + PW'(1);
        if (!primed_q && (fill >= PW'(HALF))) primed_q <= 1'b1;
      end
      valid_q <= rd_fire;
      data_q  <= rd_fire ? rd_word : '0;
      if (rs_rise)                           unf_q <= 1'b0;
      else if (rd_req && primed_q && empty)  unf_q <= 1'b1;
    end
  end

  assign rd_addr   = rptr_q[AW-1:0];
  assign rptr      = rptr_q;
  assign primed    = primed_q;
  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign unf       = unf_q;

endmodule

// File: rtl/axc_resync_txbuf.sv
module axc_resync_txbuf #(
  parameter int DATA_W = axc_txbuf_pkg::SAMPLE_W,
  parameter int DEPTH  = axc_txbuf_pkg::BUF_DEPTH,
  parameter int HOLD   = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = axc_txbuf_pkg::ptr_bits(DEPTH)
) (
  input  logic              app_clk,
  input  logic              app_rst_n,
  input  logic              app_resync,
  input  logic              app_valid,
  input  logic [DATA_W-1:0] app_data,
  output logic              app_ready,
  output logic              app_ovf,
  input  logic              line_clk,
  input  logic              line_rst_n,
  input  logic              line_rd,
  output logic [DATA_W-1:0] line_data,
  output logic              line_dvalid,
  output logic              line_unf
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] wr_fill;
  logic          wr_full;
  logic          rs_level;
  logic [PW-1:0] rptr_at_app;
  logic [PW-1:0] wptr_at_line;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] rd_fill;
  logic          rd_primed;
  logic          rd_fire;

  assign app_ready = 1'b1;

  axc_txbuf_wr #(.DEPTH(DEPTH), .HOLD(HOLD)) u_wr (
    .clk       (app_clk),
    .rst_n     (app_rst_n),
    .resync    (app_resync),
    .valid     (app_valid),
    .rptr_sync (rptr_at_app),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wptr      (wr_ptr),
    .fill      (wr_fill),
    .full      (wr_full),
    .rs_level  (rs_level),
    .ovf       (app_ovf)
  );

  always_ff @(posedge app_clk) begin
    if (wr_en) mem[wr_addr] <= app_data;
  end

  axc_ptr_xing #(.PW(PW)) u_w2l (
    .src_clk   (app_clk),
    .src_rst_n (app_rst_n),
    .src_bin   (wr_ptr),
    .dst_clk   (line_clk),
    .dst_rst_n (line_rst_n),
    .dst_bin   (wptr_at_line)
  );

  axc_ptr_xing #(.PW(PW)) u_l2w (
    .src_clk   (line_clk),
    .src_rst_n (line_rst_n),
    .src_bin   (rd_ptr),
    .dst_clk   (app_clk),
    .dst_rst_n (app_rst_n),
    .dst_bin   (rptr_at_app)
  );

  axc_txbuf_rd #(.DEPTH(DEPTH), .DW(DATA_W)) u_rd (
    .clk       (line_clk),
    .rst_n     (line_rst_n),
    .rs_level  (rs_level),
    .wptr_sync (wptr_at_line),
    .rd_req    (line_rd),
    .rd_word   (mem[rd_addr]),
    .rd_addr   (rd_addr),
    .rptr      (rd_ptr),
    .fill      (rd_fill),
    .primed    (rd_primed),
    .rd_fire   (rd_fire),
    .out_data  (line_data),
    .out_valid (line_dvalid),
    .unf       (line_unf)
  );

endmodule

// File: rtl/axc_txbuf_chk.sv
module axc_txbuf_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          app_clk,
  input logic          app_rst_n,
  input logic          app_resync,
  input logic          app_valid,
  input logic          app_ovf,
  input logic          wr_full,
  input logic [PW-1:0] wr_fill,
  input logic          line_clk,
  input logic          line_rst_n,
  input logic          line_rd,
  input logic [DW-1:0] line_data,
  input logic          line_dvalid,
  input logic          line_unf,
  input logic          rd_primed,
  input logic [PW-1:0] rd_fill,
  input logic          rd_fire
);

  // R8
  fill_bound_chk: assert property (@(posedge app_clk) disable iff (!app_rst_n)
    wr_fill <= PW'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge app_clk) disable iff (!app_rst_n)
    (wr_full && app_valid && !app_resync) |=> app_ovf);

  // R10
  ovf_sticky_chk: assert property (@(posedge app_clk) disable iff (!app_rst_n)
    (app_ovf && !app_resync) |=> app_ovf);

  // R10
  ovf_clear_chk: assert property (@(posedge app_clk) disable iff (!app_rst_n)
    app_resync |=> !app_ovf);

  // R7
  dvalid_follows_read_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    rd_fire |=> line_dvalid);

  // R6
  idle_zero_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    !line_dvalid |-> (line_data == '0));

  // R6
  no_early_output_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (line_rd && !rd_primed) |=> !line_dvalid);

  // R9
  underflow_set_chk: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (line_rd && rd_primed && (rd_fill == '0)) |=> (line_unf && !line_dvalid));

endmodule

bind axc_resync_txbuf axc_txbuf_chk #(.DEPTH(DEPTH), .DW(DATA_W)) u_chk (
  .app_clk     (app_clk),
  .app_rst_n   (app_rst_n),
  .app_resync  (app_resync),
  .app_valid   (app_valid),
  .app_ovf     (app_ovf),
  .wr_full     (wr_full),
  .wr_fill     (wr_fill),
  .line_clk    (line_clk),
  .line_rst_n  (line_rst_n),
  .line_rd     (line_rd),
  .line_data   (line_data),
  .line_dvalid (line_dvalid),
  .line_unf    (line_unf),
  .rd_primed   (rd_primed),
  .rd_fill     (rd_fill),
  .rd_fire     (rd_fire)
);

// File: tb/axc_resync_txbuf_bench.sv
module axc_resync_txbuf_bench;

  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic          app_clk = 1'b0;
  logic          line_clk = 1'b0;
  logic          app_rst_n = 1'b0;
  logic          line_rst_n = 1'b0;
  logic          app_resync = 1'b0;
  logic          app_valid = 1'b0;
  logic [DW-1:0] app_data = '0;
  logic          app_ready;
  logic          app_ovf;
  logic          line_rd = 1'b0;
  logic [DW-1:0] line_data;
  logic          line_dvalid;
  logic          line_unf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5  line_clk = ~line_clk;   // 100 MHz line side
  always #40 app_clk  = ~app_clk;    // one eighth of it

  axc_resync_txbuf u_axc_resync_txbuf (
    .app_clk     (app_clk),
    .app_rst_n   (app_rst_n),
    .app_resync  (app_resync),
    .app_valid   (app_valid),
    .app_data    (app_data),
    .app_ready   (app_ready),
    .app_ovf     (app_ovf),
    .line_clk    (line_clk),
    .line_rst_n  (line_rst_n),
    .line_rd     (line_rd),
    .line_data   (line_data),
    .line_dvalid (line_dvalid),
    .line_unf    (line_unf)
  );

  function automatic logic [DW-1:0] smp(input int tag, input int k);
    return {tag[15:0], k[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic app_step(input logic rs, input logic v, input logic [DW-1:0] d);
    @(negedge app_clk);
    app_resync = rs;
    app_valid  = v;
    app_data   = d;
  endtask

  task automatic app_idle();
    app_step(1'b0, 1'b0, '0);
  endtask

  task automatic settle();
    repeat (48) @(negedge line_clk);
  endtask

  task automatic read_expect(input logic ev, input logic [DW-1:0] ed, input string req);
    @(negedge line_clk);
    line_rd = 1'b1;
    @(negedge line_clk);
    line_rd = 1'b0;
    chk(line_dvalid === ev, req, "line_dvalid", DW'(line_dvalid), DW'(ev));
    chk(line_data === ed, req, "line_data", line_data, ed);
  endtask

  // write n samples of one tag, first one together with resync
  task automatic stream(input int tag, input int n, input bit gaps);
    app_step(1'b1, 1'b1, smp(tag, 0));
    for (int k = 1; k < n; k++) begin
      if (gaps && (k % 3 == 0)) app_step(1'b0, 1'b0, smp(16'hdead, k));
      app_step(1'b0, 1'b1, smp(tag, k));
    end
    app_idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge line_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (40) @(negedge line_clk);
    app_rst_n  = 1'b1;
    line_rst_n = 1'b1;
    repeat (4) @(negedge line_clk);

    // R11 reset state, R1 ready
    chk(line_dvalid === 1'b0, "R11", "dvalid", DW'(line_dvalid), '0);
    chk(line_data === '0, "R11", "data", line_data, '0);
    chk(app_ovf === 1'b0, "R11", "ovf", DW'(app_ovf), '0);
    chk(line_unf === 1'b0, "R11", "unf", DW'(line_unf), '0);
    chk(app_ready === 1'b1, "R1", "ready", DW'(app_ready), 1);

    // R6: below half depth nothing is emitted or consumed
    stream(1, HALF - 1, 1'b0);
    settle();
    read_expect(1'b0, '0, "R6");
    read_expect(1'b0, '0, "R6");
    chk(line_unf === 1'b0, "R6", "unf", DW'(line_unf), '0);
    app_step(1'b0, 1'b1, smp(1, HALF - 1));
    app_idle();
    settle();
    for (int k = 0; k < HALF; k++) read_expect(1'b1, smp(1, k), "R7");
    // R9 underflow on the extra read
    read_expect(1'b0, '0, "R9");
    chk(line_unf === 1'b1, "R9", "unf", DW'(line_unf), 1);

    // R2 resync with valid, R10 underflow cleared
    stream(2, HALF, 1'b0);
    settle();
    chk(line_unf === 1'b0, "R10", "unf after resync", DW'(line_unf), '0);
    for (int k = 0; k < HALF; k++) read_expect(1'b1, smp(2, k), "R2");
    read_expect(1'b0, '0, "R9");

    // R3 resync with valid low ignores its data
    app_step(1'b1, 1'b0, smp(3, 99));
    for (int k = 0; k < HALF; k++) app_step(1'b0, 1'b1, smp(3, k));
    app_idle();
    settle();
    for (int k = 0; k < HALF; k++) read_expect(1'b1, smp(3, k), "R3");
    read_expect(1'b0, '0, "R3");

    // R5 resync mid-stream drops earlier samples
    app_step(1'b1, 1'b1, smp(4, 0));
    for (int k = 1; k < 5; k++) app_step(1'b0, 1'b1, smp(4, k));
    stream(5, HALF, 1'b0);
    settle();
    for (int k = 0; k < HALF; k++) read_expect(1'b1, smp(5, k), "R5");
    read_expect(1'b0, '0, "R5");

    // R8 overflow: the write beyond DEPTH is dropped
    app_step(1'b1, 1'b1, smp(6, 0));
    for (int k = 1; k < DEPTH; k++) app_step(1'b0, 1'b1, smp(6, k));
    app_step(1'b0, 1'b1, smp(6, DEPTH));
    app_idle();
    chk(app_ovf === 1'b1, "R8", "ovf", DW'(app_ovf), 1);
    settle();
    for (int k = 0; k < DEPTH; k++) read_expect(1'b1, smp(6, k), "R8");
    read_expect(1'b0, '0, "R8");
    chk(app_ovf === 1'b1, "R10", "ovf sticky", DW'(app_ovf), 1);
    app_step(1'b1, 1'b0, '0);
    app_idle();
    chk(app_ovf === 1'b0, "R10", "ovf cleared", DW'(app_ovf), '0);

    // R4 R7 sweep every fill level from half to full, with idle gaps
    for (int n = HALF; n <= DEPTH; n++) begin
      stream(16 + n, n, 1'b1);
      settle();
      for (int k = 0; k < n; k++) read_expect(1'b1, smp(16 + n, k), "R4");
      read_expect(1'b0, '0, "R7");
      chk(line_unf === 1'b1, "R9", "unf sweep", DW'(line_unf), 1);
    end
    chk(app_ovf === 1'b0, "R8", "no ovf at exact full", DW'(app_ovf), '0);
    chk(app_ready === 1'b1, "R1", "ready end", DW'(app_ready), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule